// File: doc/BRIEF.md
# E1 Transmit Frame Builder

This block produces the serial line stream of a 2.048 Mbit/s E1 carrier. It sends one bit per clock, and each frame holds 32 time slots of 8 bits. Payload comes either from a serial input or from a byte that is held for the length of a time slot. The block keeps its own position counters for bit, time slot and frame, and a multiframe is 16 frames long. Time slot 0 is rewritten on the fly with framing overhead.

The overhead bits are grouped into six classes. Each class can be inserted on its own, or left transparent so that the payload passes through at those positions. The block computes a CRC-4 over every outgoing sub-multiframe of 8 frames and places the result in the following sub-multiframe.

The block also exposes the position of the bit it is accepting, so that an upstream source can supply the right payload. It marks the start of each frame and each multiframe with pulses that are aligned to the serial output.

Top module: `e1_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_out`, `frm_start` and `mf_start` are 0. The first clock edge after release emits frame 0, time slot 0, bit 1, with both `frm_start` and `mf_start` high for that one cycle.
- R2: `tx_out` carries, one clock later, the bit selected by the inputs in the cycle before. `frm_start` is high exactly when `tx_out` is bit 1 of time slot 0, which happens once every 256 cycles. `mf_start` is high only together with `frm_start`, and only for frame 0 of each 16-frame multiframe.
- R3: In time slots 1 to 31, the output is the payload. With `par_sel`=0 the payload is `ser_in`. With `par_sel`=1 it is `par_byte[7-bit_idx]`, so the most significant bit is sent first as bit 1.
- R4: When `cfg_ins[0]` is set, bits 2 to 8 of time slot 0 in even frames carry 0,0,1,1,0,1,1, in that order.
- R5: When `cfg_ins[1]` is set, in odd frames bit 2 of time slot 0 is 1 and bit 3 is `cfg_alarm`.
- R6: When `cfg_ins[2]` is set, bits 4 to 8 of time slot 0 in odd frames carry `cfg_sa[4]` down to `cfg_sa[0]`.
- R7: When `cfg_ins[3]` is set, bit 1 of time slot 0 in frames 1, 3, 5, 7, 9 and 11 carries 0,0,1,0,1,1, in that order.
- R8: When `cfg_ins[5]` is set, bit 1 of time slot 0 carries `cfg_e[1]` in frame 13 and `cfg_e[0]` in frame 15.
- R9: When `cfg_ins[4]` is set, bit 1 of time slot 0 in frames 0, 2, 4 and 6 (and likewise 8, 10, 12 and 14) carries C1 to C4. These bits are the remainder of the previous sub-multiframe's 2048 transmitted bits, multiplied by x^4 and divided by x^4+x+1. The bit-1 positions of even frames count as 0 in this division, and C1 is the highest-order coefficient. The first sub-multiframe after reset carries zeros.
- R10: For any overhead position whose class bit in `cfg_ins` is clear, the output at that position is the payload bit.
- R11: `frm_idx`, `ts_idx` and `bit_idx` give the frame (0 to 15), the time slot (0 to 31) and the bit (0 to 7, where 0 is bit 1) of the payload bit being accepted in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial payload bit |
| par_sel | input | 1 | 1 selects byte payload, 0 selects serial payload |
| par_byte | input | 8 | Payload byte of the current time slot, MSB first |
| cfg_ins | input | 6 | Per-class overhead insert enables |
| cfg_alarm | input | 1 | Remote alarm bit value |
| cfg_sa | input | 5 | Spare bit values Sa4..Sa8 |
| cfg_e | input | 2 | E bit values for frames 13 and 15 |
| tx_out | output | 1 | Serial E1 output |
| frm_start | output | 1 | Frame start pulse, aligned to tx_out |
| mf_start | output | 1 | Multiframe start pulse, aligned to tx_out |
| frm_idx | output | 4 | Frame number of the bit being accepted |
| ts_idx | output | 5 | Time slot of the bit being accepted |
| bit_idx | output | 3 | Bit position of the bit being accepted |

## Verification
The position outputs describe the current cycle, so the bench compares them on the same falling edge at which it drives the payload for that position. The serial bit and the two start pulses come out of a single register, one edge later. The bench therefore queues each expected bit when it drives the input, and pops the queue shortly after the next rising edge. CRC bits are due one whole sub-multiframe after the bits they cover: the bench divides its own record of the 2048 expected bits once the last one is queued, and uses that remainder for the next eight frames.

// File: rtl/e1_tx_framer.sv
module e1_tx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       par_sel,
  input  logic [7:0] par_byte,
  input  logic [5:0] cfg_ins,
  input  logic       cfg_alarm,
  input  logic [4:0] cfg_sa,
  input  logic [1:0] cfg_e,
  output logic       tx_out,
  output logic       frm_start,
  output logic       mf_start,
  output logic [3:0] frm_idx,
  output logic [4:0] ts_idx,
  output logic [2:0] bit_idx
);
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;
  localparam logic [5:0] MF_WORD    = 6'b001011;

  logic [2:0] bit_q;
  logic [4:0] ts_q;
  logic [3:0] frm_q;
  logic [3:0] crc_q, c_hold;

  wire odd      = frm_q[0];
  wire in_ts0   = (ts_q == 5'd0);
  wire first_b  = (bit_q == 3'd0);
  wire c_pos    = in_ts0 && first_b && !odd;
  wire smf_end  = (bit_q == 3'd7) && (ts_q == 5'd31) && (frm_q[2:0] == 3'd7);
  wire payload  = par_sel ? par_byte[3'd7 - bit_q] : ser_in;

  logic ovr_en, ovr_val;
  always_comb begin
    ovr_en  = 1'b0;
    ovr_val = 1'b0;
    if (in_ts0) begin
      if (first_b) begin
        if (!odd) begin
          ovr_en  = cfg_ins[4];
          ovr_val = c_hold[3'd3 - {1'b0, frm_q[2:1]}];
        end else if (frm_q < 4'd12) begin
          ovr_en  = cfg_ins[3];
          ovr_val = MF_WORD[3'd5 - frm_q[3:1]];
        end else begin
          ovr_en  = cfg_ins[5];
          ovr_val = (frm_q == 4'd13) ? cfg_e[1] : cfg_e[0];
        end
      end else if (!odd) begin
        ovr_en  = cfg_ins[0];
        ovr_val = ALIGN_WORD[3'd7 - bit_q];
      end else if (bit_q == 3'd1) begin
        ovr_en  = cfg_ins[1];
        ovr_val = 1'b1;
      end else if (bit_q == 3'd2) begin
        ovr_en  = cfg_ins[1];
        ovr_val = cfg_alarm;
      end else begin
        ovr_en  = cfg_ins[2];
        ovr_val = cfg_sa[3'd7 - bit_q];
      end
    end
  end

  wire       nxt    = ovr_en ? ovr_val : payload;
  wire       fb     = (c_pos ? 1'b0 : nxt) ^ crc_q[3];
  wire [3:0] crc_nx = {crc_q[2:0], 1'b0} ^ {2'b00, fb, fb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      ts_q      <= '0;
      frm_q     <= '0;
      crc_q     <= '0;
      c_hold    <= '0;
      tx_out    <= 1'b0;
      frm_start <= 1'b0;
      mf_start  <= 1'b0;
    end else begin
      tx_out    <= nxt;
      frm_start <= in_ts0 && first_b;
      mf_start  <= in_ts0 && first_b && (frm_q == 4'd0);
      crc_q     <= smf_end ? 4'd0 : crc_nx;
      if (smf_end) c_hold <= crc_nx;
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) ts_q <= ts_q + 5'd1;
      if (bit_q == 3'd7 && ts_q == 5'd31) frm_q <= frm_q + 4'd1;
    end
  end

  assign frm_idx = frm_q;
  assign ts_idx  = ts_q;
  assign bit_idx = bit_q;
endmodule

// File: rtl/e1_tx_framer_chk.sv
module e1_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_out,
  input logic       frm_start,
  input logic       mf_start,
  input logic [5:0] cfg_ins,
  input logic       cfg_alarm
);
  logic [8:0] gap_q;
  logic [3:0] fc_q;
  logic       fseen_q, mseen_q;

  wire [3:0] fcur = mf_start ? 4'd0 : (frm_start ? fc_q + 4'd1 : fc_q);
  wire [8:0] pos  = frm_start ? 9'd0 : gap_q;
  wire       fas_bit = (pos == 9'd3) || (pos == 9'd4) || (pos == 9'd6) || (pos == 9'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      fc_q    <= '0;
      fseen_q <= 1'b0;
      mseen_q <= 1'b0;
    end else begin
      gap_q   <= pos + 9'd1;
      fc_q    <= fcur;
      fseen_q <= fseen_q | frm_start;
      mseen_q <= mseen_q | mf_start;
    end
  end

  AST_FIRST_IS_MF: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && !fseen_q |-> mf_start); // R1
  AST_FRM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && fseen_q |-> gap_q == 9'd256); // R2
  AST_MF_ON_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> frm_start); // R2
  AST_MF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start && mseen_q |-> fc_q == 4'd15); // R2
  AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mseen_q && !fcur[0] && pos >= 9'd1 && pos <= 9'd7 && $past(cfg_ins[0]) |-> tx_out == fas_bit); // R4
  AST_ODD_B2: assert property (@(posedge clk) disable iff (!rst_n)
    mseen_q && fcur[0] && pos == 9'd1 && $past(cfg_ins[1]) |-> tx_out); // R5
  AST_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    mseen_q && fcur[0] && pos == 9'd2 && $past(cfg_ins[1]) |-> tx_out == $past(cfg_alarm)); // R5
endmodule

bind e1_tx_framer e1_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .frm_start(frm_start),
  .mf_start(mf_start), .cfg_ins(cfg_ins), .cfg_alarm(cfg_alarm)
);

// File: tb/test_e1_tx_framer.sv
`timescale 1ns/1ps
module test_e1_tx_framer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0, par_sel = 1'b0, cfg_alarm = 1'b0;
  logic [7:0] par_byte = '0;
  logic [5:0] cfg_ins = '0;
  logic [4:0] cfg_sa = '0;
  logic [1:0] cfg_e = '0;
  logic       tx_out, frm_start, mf_start;
  logic [3:0] frm_idx;
  logic [4:0] ts_idx;
  logic [2:0] bit_idx;

  e1_tx_framer i_e1_tx_framer (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .par_sel(par_sel), .par_byte(par_byte),
    .cfg_ins(cfg_ins), .cfg_alarm(cfg_alarm), .cfg_sa(cfg_sa), .cfg_e(cfg_e),
    .tx_out(tx_out), .frm_start(frm_start), .mf_start(mf_start),
    .frm_idx(frm_idx), .ts_idx(ts_idx), .bit_idx(bit_idx)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0, first_pop = 1'b1;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic smf[0:2051];
  logic [1:4] c_prev = '0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic crc_update();
    logic w[0:2051];
    for (int i = 0; i < 2048; i++) w[i] = smf[i];
    for (int i = 2048; i < 2052; i++) w[i] = 1'b0;
    for (int i = 0; i < 2048; i++)
      if (w[i]) begin
        w[i] = 1'b0; w[i+3] = ~w[i+3]; w[i+4] = ~w[i+4];
      end
    c_prev = {w[2048], w[2049], w[2050], w[2051]};
  endtask

  task automatic drive_bit(input int f, input int ts, input int b, input logic serb, input logic [7:0] byt);
    logic pay, e, ov;
    int cls;
    string tg;
    ser_in = serb;
    par_byte = byt;
    check(frm_idx == f && ts_idx == ts && bit_idx == b, "R11", "position",
          int'({frm_idx, ts_idx, bit_idx}), (f << 8) | (ts << 3) | b);
    pay = par_sel ? byt[7-b] : serb;
    cls = -1; ov = 1'b0; tg = "R3";
    if (ts == 0) begin
      if (b == 0) begin
        if (f % 2 == 0) begin cls = 4; ov = c_prev[(f / 2) % 4 + 1]; tg = "R9"; end
        else if (f < 12) begin cls = 3; ov = (f == 5 || f == 9 || f == 11); tg = "R7"; end
        else begin cls = 5; ov = (f == 13) ? cfg_e[1] : cfg_e[0]; tg = "R8"; end
      end else if (f % 2 == 0) begin
        cls = 0; ov = (b == 3 || b == 4 || b == 6 || b == 7); tg = "R4";
      end else if (b <= 2) begin
        cls = 1; ov = (b == 1) ? 1'b1 : cfg_alarm; tg = "R5";
      end else begin
        cls = 2; ov = cfg_sa[7-b]; tg = "R6";
      end
    end
    if (cls >= 0 && !cfg_ins[cls]) begin e = pay; tg = "R10"; end
    else if (cls >= 0) e = ov;
    else e = pay;
    smf[(f % 8) * 256 + ts * 8 + b] = (ts == 0 && b == 0 && f % 2 == 0) ? 1'b0 : e;
    exp_q.push_back({e, ts == 0 && b == 0, ts == 0 && b == 0 && f == 0});
    tag_q.push_back(tg);
    if (f % 8 == 7 && ts == 31 && b == 7) crc_update();
    @(negedge clk);
  endtask

  task automatic run_mf(input logic psel, input logic [5:0] ins, input logic al,
                        input logic [4:0] sa, input logic [1:0] ev);
    par_sel = psel; cfg_ins = ins; cfg_alarm = al; cfg_sa = sa; cfg_e = ev;
    for (int f = 0; f < 16; f++)
      for (int ts = 0; ts < 32; ts++) begin
        logic [7:0] byt;
        byt = 8'($urandom);
        for (int b = 0; b < 8; b++) drive_bit(f, ts, b, 1'($urandom), byt);
      end
  endtask

  logic [2:0] mon_x;
  string mon_t;
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_x = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check(tx_out == mon_x[2], mon_t, "tx bit", int'(tx_out), int'(mon_x[2]));
      check({frm_start, mf_start} == mon_x[1:0], first_pop ? "R1" : "R2", "start pulses",
            int'({frm_start, mf_start}), int'(mon_x[1:0]));
      first_pop = 1'b0;
    end
  end

  initial begin
    #(60000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cfg_ins = 6'h3F; ser_in = 1'b1; par_byte = 8'hFF;
    repeat (4) begin
      @(negedge clk);
      check({tx_out, frm_start, mf_start} == 3'b000, "R1", "reset outputs",
            int'({tx_out, frm_start, mf_start}), 0);
    end
    rst_n = 1'b1;
    run_mf(1'b0, 6'h3F, 1'b1, 5'b10110, 2'b10);
    run_mf(1'b0, 6'h3F, 1'b0, 5'b01001, 2'b01);
    run_mf(1'b1, 6'h3F, 1'b1, 5'b11100, 2'b11);
    run_mf(1'b0, 6'h00, 1'b0, 5'b00000, 2'b00);
    run_mf(1'b1, 6'b101010, 1'b1, 5'b00111, 2'b10);
    run_mf(1'b1, 6'b010101, 1'b0, 5'b11010, 2'b01);
    run_mf(1'b0, 6'h3F, 1'b1, 5'b10101, 2'b00);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule